// File: doc/BRIEF.md
# I2C Initiator Automatic Clock Stretcher

This block sits next to the bit engine of an I2C initiator. It decides, at each falling edge of SCL, whether the initiator must keep SCL low because a local FIFO cannot keep up. When transmitting, the trigger is an empty transmit FIFO. When receiving, the trigger is a full receive FIFO. The block raises a hold request for the pad logic and keeps it up until the FIFO condition clears or a programmable timeout ends the stretch. The timeout keeps the initiator from locking the bus.

A 4-bit mode field selects the behaviour. Zero turns the function off. Fifteen stretches with no time limit. Any value N in between gives a finite limit of (div_hi + div_lo + 1) × 2^N system clocks. The limit is derived from the SCL divider high and low counts. Each episode latches its limit and direction when it starts, so reprogramming during a stretch affects only later episodes. A timeout releases SCL, gives a one-cycle pulse and sets a sticky flag. Software clears that flag through a write-one-to-clear strobe.

Top module: `i2c_auto_stretch`

## Requirements
- R1: With mode equal to 0, scl_hold is never asserted and no episode starts, whatever the other inputs are.
- R2: In transmit (xfer_dir = 1), with tx_empty = 1 and a nonzero mode, an scl_fall strobe starts an episode and raises scl_hold in that same cycle. The strobe must come with slot_ack = 1 during an address byte (byte_is_addr = 1), or with slot_data = 1 during a data byte (byte_is_addr = 0).
- R3: In receive (xfer_dir = 0), with rx_full = 1, slot_ack = 1 and a nonzero mode, an scl_fall strobe starts an episode and raises scl_hold in that same cycle. In receive, byte_is_addr and tx_empty have no effect.
- R4: No episode starts without scl_fall, in a non-matching slot, or when only the FIFO flag of the other direction is set.
- R5: For a mode N from 1 to 14, if the FIFO condition persists, scl_hold stays high for exactly (div_hi + div_lo + 1) × 2^N cycles, counting the trigger cycle. timeout_pulse is then high for exactly one cycle, which is the first cycle in which scl_hold is low.
- R6: With mode equal to 15, an episode never times out. scl_hold stays high for as long as the FIFO condition persists.
- R7: scl_hold falls in the same cycle in which the FIFO condition of the episode's direction clears. No timeout_pulse is given.
- R8: If the FIFO condition clears in the very cycle in which the limit would be reached, the release wins. There is no timeout_pulse and timeout_sticky is not set.
- R9: timeout_sticky becomes 1 in the cycle after a timeout_pulse. It becomes 0 in the cycle after sticky_clr = 1. A timeout in the same cycle as sticky_clr leaves it set.
- R10: Changes to mode, div_hi or div_lo after the trigger cycle do not change the length of the current episode.
- R11: stretch_active rises in the cycle after the trigger and falls one cycle after scl_hold falls.
- R12: After reset, scl_hold, stretch_active, timeout_pulse and timeout_sticky are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 4 | Stretch mode: 0 off, 1..14 finite limit exponent, 15 unlimited |
| div_hi | input | DIV_W | SCL divider high count |
| div_lo | input | DIV_W | SCL divider low count |
| scl_fall | input | 1 | One-cycle strobe at an SCL falling edge from the bit engine |
| xfer_dir | input | 1 | 1 = initiator transmits, 0 = initiator receives |
| byte_is_addr | input | 1 | Current byte is the address byte |
| slot_ack | input | 1 | The coming slot is the acknowledge bit |
| slot_data | input | 1 | The coming slot is the first data bit |
| tx_empty | input | 1 | Transmit FIFO is empty |
| rx_full | input | 1 | Receive FIFO is full |
| sticky_clr | input | 1 | Write-one-to-clear strobe for timeout_sticky |
| scl_hold | output | 1 | Request to hold SCL low |
| stretch_active | output | 1 | A stretch episode is in progress |
| timeout_pulse | output | 1 | One-cycle pulse when an episode times out |
| timeout_sticky | output | 1 | Sticky record of a timeout |

## Verification
Two events can fall in the same cycle and need a priority: the FIFO condition can clear just as the counter reaches its limit, and a timeout can expire just as software clears the sticky flag. The bench provokes the first by dropping the FIFO flag exactly at the computed expiry cycle and checks that scl_hold was high for the full limit, that there was no pulse and that the sticky flag stayed clear. It provokes the second by strobing sticky_clr in the expiry cycle and checks that the flag ends up set.

// File: rtl/i2c_stretch_pkg.sv
package i2c_stretch_pkg;
   localparam int MODE_W = 4;
   localparam logic [MODE_W-1:0] MODE_OFF     = '0;
   localparam logic [MODE_W-1:0] MODE_FOREVER = '1;
   // largest finite exponent: every code except off and unlimited
   localparam int EXP_MAX = (1 << MODE_W) - 2;

   typedef enum logic {
      XFER_RX = 1'b0,
      XFER_TX = 1'b1
   } xfer_dir_e;
endpackage

// File: rtl/stretch_trigger.sv
module stretch_trigger
   import i2c_stretch_pkg::*;
(
   input  logic [MODE_W-1:0] mode,
   input  logic              idle,
   input  logic              scl_fall,
   input  logic              xfer_dir,
   input  logic              byte_is_addr,
   input  logic              slot_ack,
   input  logic              slot_data,
   input  logic              tx_empty,
   input  logic              rx_full,
   output logic              fire
);
   xfer_dir_e dir;
   logic      tx_slot;
   logic      want_tx;
   logic      want_rx;

   always_comb begin
      dir     = xfer_dir_e'(xfer_dir);
      // address byte stalls before its acknowledge, data byte before its bits
      tx_slot = byte_is_addr ? slot_ack : slot_data;
      want_tx = (dir == XFER_TX) && tx_empty && tx_slot;
      want_rx = (dir == XFER_RX) && rx_full && slot_ack;
      fire    = idle && scl_fall && (mode != MODE_OFF) && (want_tx || want_rx);
   end
endmodule

// File: rtl/stretch_timer.sv
module stretch_timer
   import i2c_stretch_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              armed,
   input  logic              cond,
   input  logic [MODE_W-1:0] mode,
   input  logic [DIV_W-1:0]  div_hi,
   input  logic [DIV_W-1:0]  div_lo,
   output logic              expire
);
   localparam int BASE_W = DIV_W + 1;
   localparam int CNT_W  = BASE_W + EXP_MAX;

   logic [BASE_W-1:0] base;
   logic [CNT_W-1:0]  cand [EXP_MAX+1];
   logic [CNT_W-1:0]  lim_next;
   logic [CNT_W-1:0]  lim_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              forever_q;

   assign base = {1'b0, div_hi} + {1'b0, div_lo} + BASE_W'(1);

   // one pre-shifted limit per exponent, selected by the mode code
   for (genvar g = 0; g <= EXP_MAX; g++) begin : g_cand
      assign cand[g] = CNT_W'(base) << g;
   end

   always_comb begin
      lim_next = cand[0];
      for (int e = 1; e <= EXP_MAX; e++) begin
         if (mode == MODE_W'(e)) lim_next = cand[e];
      end
   end

   assign expire = armed && cond && !forever_q && (cnt_q >= lim_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim_q     <= '0;
         cnt_q     <= '0;
         forever_q <= 1'b0;
      end else if (load) begin
         lim_q     <= lim_next;
         cnt_q     <= CNT_W'(1);   // trigger cycle already held
         forever_q <= (mode == MODE_FOREVER);
      end else if (armed && cond && !expire && !forever_q) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/i2c_auto_stretch.sv
module i2c_auto_stretch
   import i2c_stretch_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode,
   input  logic [DIV_W-1:0]  div_hi,
   input  logic [DIV_W-1:0]  div_lo,
   input  logic              scl_fall,
   input  logic              xfer_dir,
   input  logic              byte_is_addr,
   input  logic              slot_ack,
   input  logic              slot_data,
   input  logic              tx_empty,
   input  logic              rx_full,
   input  logic              sticky_clr,
   output logic              scl_hold,
   output logic              stretch_active,
   output logic              timeout_pulse,
   output logic              timeout_sticky
);
   if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div_w
      $error("DIV_W must lie in 1..16");
   end

   logic      busy_q;
   xfer_dir_e dir_q;
   logic      sticky_q;
   logic      fire;
   logic      cond;
   logic      expire;

   stretch_trigger u_trig (
      .mode         (mode),
      .idle         (!busy_q),
      .scl_fall     (scl_fall),
      .xfer_dir     (xfer_dir),
      .byte_is_addr (byte_is_addr),
      .slot_ack     (slot_ack),
      .slot_data    (slot_data),
      .tx_empty     (tx_empty),
      .rx_full      (rx_full),
      .fire         (fire)
   );

   // FIFO condition of the direction latched for this episode
   assign cond = (dir_q == XFER_TX) ? tx_empty : rx_full;

   stretch_timer #(.DIV_W(DIV_W)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (fire),
      .armed  (busy_q),
      .cond   (cond),
      .mode   (mode),
      .div_hi (div_hi),
      .div_lo (div_lo),
      .expire (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         dir_q  <= XFER_RX;
      end else if (fire) begin
         busy_q <= 1'b1;
         dir_q  <= xfer_dir_e'(xfer_dir);
      end else if (busy_q && (!cond || expire)) begin
         busy_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sticky_q <= 1'b0;
      else        sticky_q <= expire || (sticky_q && !sticky_clr);
   end

   assign scl_hold       = fire || (busy_q && cond && !expire);
   assign stretch_active = busy_q;
   assign timeout_pulse  = expire;
   assign timeout_sticky = sticky_q;
endmodule

// File: rtl/i2c_auto_stretch_chk.sv
module i2c_auto_stretch_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] mode,
   input logic       scl_fall,
   input logic       sticky_clr,
   input logic       scl_hold,
   input logic       stretch_active,
   input logic       timeout_pulse,
   input logic       timeout_sticky
);
   p_off_no_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!stretch_active && mode == 4'd0) |-> !scl_hold);

   p_hold_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
      scl_hold |-> (stretch_active || scl_fall));

   p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_pulse |=> !timeout_pulse);

   p_pulse_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_pulse |-> (!scl_hold && stretch_active));

   p_pulse_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_pulse |=> timeout_sticky);

   p_clear_works_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_clr && !timeout_pulse) |=> !timeout_sticky);

   p_sticky_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout_sticky && !sticky_clr) |=> timeout_sticky);

   p_active_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_hold && !stretch_active) |=> stretch_active);
endmodule

bind i2c_auto_stretch i2c_auto_stretch_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .mode           (mode),
   .scl_fall       (scl_fall),
   .sticky_clr     (sticky_clr),
   .scl_hold       (scl_hold),
   .stretch_active (stretch_active),
   .timeout_pulse  (timeout_pulse),
   .timeout_sticky (timeout_sticky)
);

// File: tb/sim_i2c_auto_stretch.sv
`timescale 1ns/1ps
module sim_i2c_auto_stretch;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] mode = 4'd0;
   logic [7:0] div_hi = 8'd1;
   logic [7:0] div_lo = 8'd1;
   logic       scl_fall = 1'b0;
   logic       xfer_dir = 1'b0;
   logic       byte_is_addr = 1'b0;
   logic       slot_ack = 1'b0;
   logic       slot_data = 1'b0;
   logic       tx_empty = 1'b0;
   logic       rx_full = 1'b0;
   logic       sticky_clr = 1'b0;
   logic       scl_hold;
   logic       stretch_active;
   logic       timeout_pulse;
   logic       timeout_sticky;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   i2c_auto_stretch #(.DIV_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .mode(mode), .div_hi(div_hi), .div_lo(div_lo),
      .scl_fall(scl_fall), .xfer_dir(xfer_dir), .byte_is_addr(byte_is_addr),
      .slot_ack(slot_ack), .slot_data(slot_data), .tx_empty(tx_empty),
      .rx_full(rx_full), .sticky_clr(sticky_clr), .scl_hold(scl_hold),
      .stretch_active(stretch_active), .timeout_pulse(timeout_pulse),
      .timeout_sticky(timeout_sticky)
   );

   // {fall, mode[3:0], dir, addr, ack, data, tx_empty, rx_full, expected hold}
   localparam logic [11:0] VEC [13] = '{
      12'b1_0001_1_1_1_0_1_0_1,  // R2 address byte, ack slot
      12'b1_0001_1_1_0_1_1_0_0,  // R4 address byte, data slot
      12'b1_0001_1_0_0_1_1_0_1,  // R2 data byte, data slot
      12'b1_0001_1_0_1_0_1_0_0,  // R4 data byte, ack slot
      12'b1_0001_1_0_0_1_0_1_0,  // R4 transmit, only rx_full set
      12'b1_0001_0_0_1_0_0_1_1,  // R3 receive full at ack
      12'b1_0001_0_0_0_1_0_1_0,  // R4 receive, wrong slot
      12'b1_0001_0_0_1_0_1_0_0,  // R4 receive, only tx_empty set
      12'b1_0000_1_0_0_1_1_0_0,  // R1 disabled, transmit
      12'b1_0000_0_0_1_0_0_1_0,  // R1 disabled, receive
      12'b1_1111_0_0_1_0_0_1_1,  // R3 unlimited mode
      12'b1_0111_1_1_1_0_1_0_1,  // R2 mode 7
      12'b0_0001_1_0_0_1_1_0_0   // R4 no falling edge
   };

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_ep(input bit tx, input int total, input int clr_fifo_at,
                         input int clr_stk_at, input int chg_at,
                         output int holds, output int pulses, output int act_cyc);
      holds = 0; pulses = 0; act_cyc = 0;
      for (int k = 0; k < total; k++) begin
         @(negedge clk);
         scl_fall = (k == 0);
         if (k == 0) begin
            xfer_dir = tx; byte_is_addr = 1'b0;
            slot_ack = !tx; slot_data = tx;
            tx_empty = tx; rx_full = !tx;
         end else begin
            slot_ack = 1'b0; slot_data = 1'b0;
         end
         if (k == clr_fifo_at) begin tx_empty = 1'b0; rx_full = 1'b0; end
         sticky_clr = (k == clr_stk_at);
         if (k == chg_at) begin mode = 4'd3; div_hi = 8'd9; end
         #2;
         holds   += int'(scl_hold);
         pulses  += int'(timeout_pulse);
         act_cyc += int'(stretch_active);
      end
      @(negedge clk);
      scl_fall = 1'b0; sticky_clr = 1'b0; tx_empty = 1'b0; rx_full = 1'b0;
   endtask

   task automatic clear_sticky();
      @(negedge clk); sticky_clr = 1'b1;
      @(negedge clk); sticky_clr = 1'b0;
      #2 check("R9 cleared by strobe", int'(timeout_sticky), 0);
   endtask

   initial begin
      #1500000;
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      int h, p, a;
      repeat (3) @(negedge clk);
      #2;
      check("R12 reset hold", int'(scl_hold), 0);
      check("R12 reset active", int'(stretch_active), 0);
      check("R12 reset pulse", int'(timeout_pulse), 0);
      check("R12 reset sticky", int'(timeout_sticky), 0);
      @(negedge clk); rst_n = 1'b1;

      // trigger table: R1 R2 R3 R4
      for (int i = 0; i < 13; i++) begin
         logic [11:0] v;
         v = VEC[i];
         @(negedge clk);
         scl_fall = v[11]; mode = v[10:7]; xfer_dir = v[6]; byte_is_addr = v[5];
         slot_ack = v[4]; slot_data = v[3]; tx_empty = v[2]; rx_full = v[1];
         #2 check($sformatf("R1 R2 R3 R4 vector %0d hold", i), int'(scl_hold), int'(v[0]));
         @(negedge clk);
         scl_fall = 1'b0; slot_ack = 1'b0; slot_data = 1'b0;
         tx_empty = 1'b0; rx_full = 1'b0;
         #2 check($sformatf("R11 vector %0d active", i), int'(stretch_active), int'(v[0]));
         check($sformatf("R7 vector %0d released", i), int'(scl_hold), 0);
         @(negedge clk);
         #2 check($sformatf("R11 vector %0d idle", i), int'(stretch_active), 0);
      end

      // R5 transmit timeout, base 3, N = 1
      mode = 4'd1; div_hi = 8'd1; div_lo = 8'd1;
      run_ep(1'b1, 12, -1, -1, -1, h, p, a);
      check("R5 tx hold length", h, 6);
      check("R5 tx pulse count", p, 1);
      check("R11 tx active length", a, 6);
      check("R9 sticky set", int'(timeout_sticky), 1);
      clear_sticky();

      // R5 receive timeout, base 3, N = 2
      mode = 4'd2; div_hi = 8'd2; div_lo = 8'd0;
      run_ep(1'b0, 20, -1, -1, -1, h, p, a);
      check("R5 rx hold length", h, 12);
      check("R5 rx pulse count", p, 1);

      // R5 largest exponent, base 1
      mode = 4'd14; div_hi = 8'd0; div_lo = 8'd0;
      run_ep(1'b1, 16390, -1, -1, -1, h, p, a);
      check("R5 N=14 hold length", h, 16384);
      check("R5 N=14 pulse count", p, 1);

      // R10 reprogramming mid-episode
      mode = 4'd1; div_hi = 8'd1; div_lo = 8'd1;
      run_ep(1'b1, 12, -1, -1, 2, h, p, a);
      check("R10 hold length kept", h, 6);
      check("R10 pulse count", p, 1);

      // R6 unlimited, released by FIFO
      mode = 4'd15; div_hi = 8'd0; div_lo = 8'd0;
      run_ep(1'b1, 300, 250, -1, -1, h, p, a);
      check("R6 unlimited hold length", h, 250);
      check("R6 no pulse", p, 0);
      check("R11 unlimited active length", a, 250);

      // R7 early release, receive
      clear_sticky();
      mode = 4'd1; div_hi = 8'd1; div_lo = 8'd1;
      run_ep(1'b0, 12, 3, -1, -1, h, p, a);
      check("R7 early hold length", h, 3);
      check("R7 early no pulse", p, 0);

      // R8 release one cycle before expiry, then exactly at expiry
      run_ep(1'b1, 12, 5, -1, -1, h, p, a);
      check("R8 pre-expiry hold length", h, 5);
      check("R8 pre-expiry no pulse", p, 0);
      run_ep(1'b1, 12, 6, -1, -1, h, p, a);
      check("R8 tie hold length", h, 6);
      check("R8 tie no pulse", p, 0);
      check("R8 tie sticky clear", int'(timeout_sticky), 0);

      // R9 clear strobe in the expiry cycle
      run_ep(1'b1, 12, -1, 6, -1, h, p, a);
      check("R9 collision pulse", p, 1);
      check("R9 set wins over clear", int'(timeout_sticky), 1);
      clear_sticky();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule